// File: doc/BRIEF.md
# CRC Single-Byte Update Unit

This unit performs one step of a running CRC for a processor's custom-instruction path. Each call supplies the current accumulator value, a data word and a 4-bit sub-opcode. The unit folds exactly one byte of the data word into the accumulator and returns the new accumulator value one clock later. The sub-opcode selects the CRC variant (8-bit, one of two 16-bit polynomials, or 32-bit) and which byte of the data word is used.

The caller owns everything around the step. It seeds the accumulator, walks the byte array, and applies any output inversion. The unit never adds an initial value or a final XOR. A new request may be issued on every clock. Codes outside the CRC range return the accumulator untouched and raise an illegal-operation flag.

Top module: `crc_step_unit`

## Requirements
- R1: `in_op` bit 3 set marks a CRC operation. Bits 1:0 pick the variant: 0 = CRC8, 1 = CRC16 with polynomial 0x8005, 2 = CRC16 with polynomial 0x1021, 3 = CRC32. Bit 2 picks the byte.
- R2: With `in_op` bit 2 clear, the unit consumes `in_data[7:0]`. With bit 2 set, it consumes `in_data[15:8]`. The remaining data bits have no effect on the result.
- R3: CRC32 uses polynomial 0x04C11DB7, processed MSB-first. The byte is XORed into accumulator bits 31:24, then eight left shifts follow. Each shift XORs in the polynomial when the bit shifted out was 1. No initial value or final XOR is applied, so accumulator 0 with byte 0x01 gives 0x04C11DB7.
- R4: The CRC16 variants use only `in_acc[15:0]`. The byte is aligned to bits 15:8, and result bits 31:16 are zero. With accumulator 0 and byte 0x01, the results are 0x8005 and 0x1021.
- R5: CRC8 uses polynomial 0x07 on `in_acc[7:0]`, and result bits 31:8 are zero. Accumulator 0 with byte 0x01 gives 0x07.
- R6: Sub-opcodes 0x0 to 0x7 return `in_acc` unchanged with `out_illegal` = 1. Every CRC sub-opcode gives `out_illegal` = 0.
- R7: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. Requests on consecutive cycles each produce their own result.
- R8: In a cycle after `in_valid` was low, `out_crc` and `out_illegal` keep their previous values, whatever the inputs do.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_crc` and `out_illegal` to zero.
- R10: Run the CRC32 low-byte step over 512 bytes (byte i = i mod 256), with seed 0xFFFFFFFF and a final XOR of 0xFFFFFFFF done by the caller. The result is 0x2F728526.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Sub-opcode selecting variant and byte |
| in_acc | input | 32 | Running CRC accumulator operand |
| in_data | input | 32 | Data operand holding the byte to fold |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_crc | output | 32 | Updated accumulator |
| out_illegal | output | 1 | Sub-opcode was not a CRC operation |

## Verification
The assertions rely on one input condition: `in_op`, `in_acc` and `in_data` are settled whenever `in_valid` is sampled high. The properties that compare against the previous cycle's operands depend on this. Outside a strobe, the assertions assume nothing about the operands.

The bench drives every input half a period away from the sampling edge. It scrambles the operands on idle cycles, so the hold property is exercised with changing inputs rather than constant ones. Reset is asserted from time zero and again mid-run, while no request is outstanding.

// File: rtl/crc_step_pkg.sv
package crc_step_pkg;
  localparam int CRC_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int OP_W    = 4;
  localparam int N_KINDS = 4;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = 8;

  typedef enum logic [1:0] {
    KIND_CRC8   = 2'd0,
    KIND_CRC16A = 2'd1,
    KIND_CRC16B = 2'd2,
    KIND_CRC32  = 2'd3
  } crc_kind_e;

  typedef struct packed {
    logic      legal;
    logic      hi_byte;
    crc_kind_e kind;
  } op_dec_t;

  function automatic int kind_width(input int k);
    case (k)
      0:       return 8;
      1, 2:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] kind_poly(input int k);
    case (k)
      0:       return 32'h0000_0007;
      1:       return 32'h0000_8005;
      2:       return 32'h0000_1021;
      default: return 32'h04C1_1DB7;
    endcase
  endfunction

  // The state is left-aligned in a 32-bit frame, so one loop serves every width.
  function automatic logic [CRC_W-1:0] fold_byte(input int width,
                                                 input logic [CRC_W-1:0] poly,
                                                 input logic [CRC_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] s;
    logic [CRC_W-1:0] p;
    s = acc << (CRC_W - width);
    p = poly << (CRC_W - width);
    s = s ^ {b, {(CRC_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      s = s[CRC_W-1] ? ((s << 1) ^ p) : (s << 1);
    end
    return s >> (CRC_W - width);
  endfunction
endpackage

// File: rtl/crc_op_decode.sv
module crc_op_decode
  import crc_step_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_dec_t         dec
);
  always_comb begin
    dec.legal   = op[3];
    dec.hi_byte = op[2];
    dec.kind    = crc_kind_e'(op[1:0]);
  end
endmodule

// File: rtl/crc_fold_lane.sv
module crc_fold_lane
  import crc_step_pkg::*;
#(
  parameter int               WIDTH = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7
) (
  input  logic [CRC_W-1:0]  acc,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  res
);
  always_comb res = fold_byte(WIDTH, POLY, acc, din);
endmodule

// File: rtl/crc_result_reg.sv
module crc_result_reg
  import crc_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CRC_W-1:0] d_crc,
  input  logic             d_illegal,
  output logic             q_valid,
  output logic [CRC_W-1:0] q_crc,
  output logic             q_illegal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      q_crc     <= '0;
      q_illegal <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_crc     <= d_crc;
        q_illegal <= d_illegal;
      end
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    load |=> q_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !load |=> !q_valid);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(q_crc) && $stable(q_illegal)));
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!q_valid && q_crc == '0 && !q_illegal));
endmodule

// File: rtl/crc_step_unit.sv
module crc_step_unit
  import crc_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic [CRC_W-1:0] in_acc,
  input  logic [CRC_W-1:0] in_data,
  output logic             out_valid,
  output logic [CRC_W-1:0] out_crc,
  output logic             out_illegal
);
  op_dec_t           dec;
  logic [BYTE_W-1:0] fold_in;
  logic [CRC_W-1:0]  lane_res [N_KINDS];
  logic [CRC_W-1:0]  next_crc;
  logic              next_illegal;

  crc_op_decode u_dec (.op(in_op), .dec(dec));

  always_comb fold_in = dec.hi_byte ? in_data[HI_LSB +: BYTE_W] : in_data[LO_LSB +: BYTE_W];

  generate
    for (genvar k = 0; k < N_KINDS; k++) begin : g_lane
      crc_fold_lane #(
        .WIDTH(kind_width(k)),
        .POLY (kind_poly(k))
      ) u_lane (
        .acc(in_acc),
        .din(fold_in),
        .res(lane_res[k])
      );
    end
  endgenerate

  always_comb begin
    next_illegal = !dec.legal;
    next_crc     = dec.legal ? lane_res[dec.kind] : in_acc;
  end

  crc_result_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .load     (in_valid),
    .d_crc    (next_crc),
    .d_illegal(next_illegal),
    .q_valid  (out_valid),
    .q_crc    (out_crc),
    .q_illegal(out_illegal)
  );

  // R6: non-CRC codes pass the accumulator through and flag it
  a_r6_illegal_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op[3]) |=> (out_illegal && out_crc == $past(in_acc)));
  a_r6_legal_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[3]) |=> !out_illegal);
  a_r5_crc8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[3] && in_op[1:0] == 2'd0) |=> (out_crc[CRC_W-1:8] == '0));
  a_r4_crc16_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[3] && (in_op[1:0] == 2'd1 || in_op[1:0] == 2'd2))
      |=> (out_crc[CRC_W-1:16] == '0));
  a_r3_crc32_zero_in: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'hB && in_acc == '0 && in_data[7:0] == 8'h00)
      |=> (out_crc == '0));
endmodule

// File: tb/crc_step_unit_tb_top.sv
module crc_step_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [31:0] in_acc = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_crc;
  logic        out_illegal;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] crc;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  crc_step_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_acc(in_acc), .in_data(in_data), .out_valid(out_valid),
    .out_crc(out_crc), .out_illegal(out_illegal)
  );

  // Bit-at-a-time reference: feed each data bit against the current top bit.
  function automatic logic [31:0] ref_step(input logic [3:0] op,
                                           input logic [31:0] acc,
                                           input logic [31:0] data);
    int w;
    logic [31:0] poly, mask, c;
    logic [7:0] b;
    logic fb;
    if (!op[3]) return acc;
    case (op[1:0])
      2'd0: begin w = 8;  poly = 32'h07; end
      2'd1: begin w = 16; poly = 32'h8005; end
      2'd2: begin w = 16; poly = 32'h1021; end
      default: begin w = 32; poly = 32'h04C11DB7; end
    endcase
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    b = op[2] ? data[15:8] : data[7:0];
    c = acc & mask;
    for (int i = 7; i >= 0; i--) begin
      fb = ((c >> (w - 1)) & 32'h1) != 0;
      fb = fb ^ b[i];
      c = (c << 1) & mask;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [31:0] acc, input logic [31:0] data,
                      input logic [31:0] exp_crc, input logic exp_ill, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_acc = acc; in_data = data;
    e.crc = exp_crc; e.ill = exp_ill; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_acc = $urandom; in_data = $urandom; in_op = 4'($urandom);
  endtask

  // Monitor: compares each result against the oldest expectation.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check("R7 unexpected valid", 1'b0, out_crc, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, out_crc === e.crc && out_illegal === e.ill,
              {out_crc[30:0], out_illegal}, {e.crc[30:0], e.ill});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] acc, held;
    logic        held_ill;
    repeat (3) @(negedge clk);
    check("R9 reset valid", out_valid == 1'b0, {31'h0, out_valid}, 32'h0);
    check("R9 reset crc", out_crc == 32'h0, out_crc, 32'h0);
    check("R9 reset illegal", out_illegal == 1'b0, {31'h0, out_illegal}, 32'h0);
    rst = 1'b0;

    // R3 R4 R5: single-bit impulse gives the polynomial itself
    send(4'hB, 32'h0, 32'h0000_0001, 32'h04C11DB7, 1'b0, "R3 crc32 impulse");
    send(4'h9, 32'h0, 32'h0000_0001, 32'h0000_8005, 1'b0, "R4 crc16a impulse");
    send(4'hA, 32'h0, 32'h0000_0001, 32'h0000_1021, 1'b0, "R4 crc16b impulse");
    send(4'h8, 32'h0, 32'h0000_0001, 32'h0000_0007, 1'b0, "R5 crc8 impulse");
    // R2: high-byte forms take bits 15:8, other bits are junk
    send(4'hF, 32'h0, 32'hABCD_01EE, 32'h04C11DB7, 1'b0, "R2 crc32 high byte");
    send(4'hC, 32'h0, 32'h5A5A_0133, 32'h0000_0007, 1'b0, "R2 crc8 high byte");
    // R6: illegal codes pass through
    send(4'h0, 32'hDEAD_BEEF, 32'h1234_5678, 32'hDEAD_BEEF, 1'b1, "R6 op0 passthru");
    send(4'h7, 32'h0BAD_F00D, 32'hFFFF_FFFF, 32'h0BAD_F00D, 1'b1, "R6 op7 passthru");
    idle();
    idle();

    // R1 R4 R5 R7: back-to-back sweep of every code with junk upper bits
    for (int op = 0; op < 16; op++) begin
      logic [31:0] a, d;
      a = $urandom; d = $urandom;
      send(4'(op), a, d, ref_step(4'(op), a, d), op < 8, $sformatf("R1 sweep op%0d", op));
    end
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a, d;
      logic [3:0] o;
      a = $urandom; d = $urandom; o = 4'($urandom);
      send(o, a, d, ref_step(o, a, d), !o[3], "R7 back-to-back");
    end
    idle();
    idle();

    // R8: hold with scrambled inputs
    send(4'hD, 32'h1234_5678, 32'h0000_9900, ref_step(4'hD, 32'h1234_5678, 32'h0000_9900), 1'b0, "R8 setup");
    idle();
    held = out_crc; held_ill = out_illegal;
    for (int n = 0; n < 4; n++) begin
      idle();
      check("R8 hold crc", out_crc == held && out_illegal == held_ill && !out_valid, out_crc, held);
    end

    // R9: mid-run reset
    rst = 1'b1;
    idle();
    idle();
    check("R9 mid reset", out_crc == 32'h0 && !out_valid && !out_illegal, out_crc, 32'h0);
    rst = 1'b0;
    idle();

    // R10: caller-driven 512-byte message, feeding the unit's output back
    acc = 32'hFFFF_FFFF;
    for (int i = 0; i < 512; i++) begin
      logic [31:0] d;
      d = {24'h0, 8'(i)};
      send(4'hB, acc, d, ref_step(4'hB, acc, d), 1'b0, "R10 message step");
      @(negedge clk);
      in_valid = 1'b0;
      acc = out_crc;
    end
    check("R10 message crc", (acc ^ 32'hFFFF_FFFF) == 32'h2F728526, acc ^ 32'hFFFF_FFFF, 32'h2F728526);
    idle();
    idle();
    check("R7 queue drained", sb_q.size() == 0, sb_q.size(), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule